// File: doc/BRIEF.md
# Display Supply Power-Up Sequencer

This block steps a multi-rail display supply through a timed bring-up. A shared ramp timer counts a programmable number of clock cycles and marks six consecutive ramp periods. Each rail enable is tied to a numbered ramp: the reference, then the main boost with its soft-start, then the negative rail, then the positive rail. Good-level flags from the rails are sampled at fixed points. Any fault, including a thermal trip, latches the whole supply off. The latch clears only when the enable input or the input-supply-ok flag goes low for at least one cycle.

Once the sequence has completed, the block drives the three one-hot select lines of the output switch from a control pin. Before completion the switch is held on its ground path. Every change of path passes through one cycle with all paths open. The ramp period in clock cycles is a parameter, so every fault timeout scales linearly with it. The current ramp number and a completion flag are exposed so that the sequence can be observed.

Top module: `rail_seq_ctrl`

## Requirements
- R1: While reset is asserted, and in the cycle after `en` or `vin_ok` is sampled low, `ramp_idx` is 0, `rail_en` is 0, `fault_latched` is 0 and `seq_done` is 0. Reset puts the switch on its ground path (`sw_gnd`=1).
- R2: With `en` and `vin_ok` high and no fault, `ramp_idx` becomes 1 one cycle later. Each ramp lasts RAMP_CYCLES cycles, and `ramp_idx` advances by one at the last cycle of each ramp. After ramp 6 it reaches 7, and 7 means the sequence is complete.
- R3: `rail_en[0]` (reference) is high exactly while `ramp_idx` is 2 or more, that is from the first peak onward.
- R4: `rail_en[1]` (main boost and its soft-start) is high from the start of ramp 3 onward.
- R5: `boost_good` is sampled in the last cycle of ramp 3. If it is low there, `fault_latched` is high in the next cycle.
- R6: `rail_en[2]` (negative rail) rises at the fourth peak, when ramp 5 starts. `rail_en[3]` (positive rail) rises at the start of ramp 6.
- R7: `neg_good` and `pos_good` are sampled in the last cycle of ramp 6. If either is low, a fault is latched. If both are high, `seq_done` rises in the next cycle.
- R8: After a rail has passed its check, a low on its good flag latches a fault in the next cycle.
- R9: `therm_trip` sampled high while `en` and `vin_ok` are high latches a fault in the next cycle, in any ramp, including ramp 1.
- R10: In a latched fault, `rail_en` is 0 and `ramp_idx` is 0, and the switch returns to ground. The latch holds while `en` and `vin_ok` stay high. Dropping either one for one cycle clears it, and the sequence restarts once both are high again.
- R11: The switch select target is the ground path until `seq_done`. After that it is the lower-rail path when `ctl` is 0 and the upper-rail path when `ctl` is 1. Each select output is registered.
- R12: At most one of `sw_gnd`, `sw_low`, `sw_high` is high in any cycle. A change from one path to another always inserts exactly one cycle with all three low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Sequencer enable; low clears a latched fault |
| vin_ok | input | 1 | Input supply above undervoltage threshold (comparator with hysteresis) |
| therm_trip | input | 1 | Thermal shutdown request |
| boost_good | input | 1 | Main boost output above its fault level |
| neg_good | input | 1 | Negative rail within its fault level |
| pos_good | input | 1 | Positive rail above its fault level |
| ctl | input | 1 | Switch control pin: 0 lower rail, 1 upper rail |
| rail_en | output | 4 | Enables: bit0 reference, bit1 boost, bit2 negative rail, bit3 positive rail |
| sw_gnd | output | 1 | Switch select: ground path |
| sw_low | output | 1 | Switch select: lower-rail path |
| sw_high | output | 1 | Switch select: upper-rail path |
| ramp_idx | output | 3 | Current ramp number: 0 idle or fault, 1 to 6 ramps, 7 complete |
| seq_done | output | 1 | Sequence complete |
| fault_latched | output | 1 | Fault latch state |

## Verification
On every cycle the assertions check the following: the switch selects are one-hot-or-none and break before make, a non-ground path appears only around completion, the ramp number never skips, the fault latch holds while the supply stays enabled, and a thermal trip or a post-check rail drop forces a fault. Only the bench's scenarios can show the exact cycles of each enable edge and each sample point. The same holds for the fault raised by a failed check at the end of ramp 3 or ramp 6, and for a restart after the latch has been cleared through either release input. The bench's reference model counts ramps and ticks with plain integers and compares every output on every cycle.

// File: rtl/rail_seq_pkg.sv
// Shared constants for the power-up sequencer: ramp numbering, the stage at
// which each rail turns on and the one-hot switch path codes.
// Assumes exactly six ramps, so a 3-bit ramp number covers idle..done.
package rail_seq_pkg;
    localparam int unsigned IDX_W     = 3;
    localparam int unsigned NUM_RAILS = 4;

    localparam logic [IDX_W-1:0] IDX_IDLE      = 3'd0;
    localparam logic [IDX_W-1:0] IDX_DONE      = 3'd7;
    localparam logic [IDX_W-1:0] STG_BOOST_CHK = 3'd3;
    localparam logic [IDX_W-1:0] STG_RAIL_CHK  = 3'd6;

    // one-hot switch select: bit0 ground, bit1 lower rail, bit2 upper rail
    typedef enum logic [2:0] {
        PATH_OFF  = 3'b000,
        PATH_GND  = 3'b001,
        PATH_LOW  = 3'b010,
        PATH_HIGH = 3'b100
    } path_t;

    // first ramp number in which each rail enable is high
    function automatic logic [IDX_W-1:0] rail_on_stage(input int unsigned rail);
        case (rail)
            0:       return 3'd2;  // reference: after first peak
            1:       return 3'd3;  // boost: start of ramp 3
            2:       return 3'd5;  // negative rail: fourth peak
            default: return 3'd6;  // positive rail: start of ramp 6
        endcase
    endfunction
endpackage

// File: rtl/rail_seq_timer.sv
// Ramp timer: counts RAMP_CYCLES clocks per ramp and flags the last cycle
// (the peak). Wraps to zero after the peak, so it restarts on its own.
// Assumes RAMP_CYCLES >= 2; clr holds the count at zero.
module rail_seq_timer #(
    parameter int unsigned RAMP_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic peak
);
    localparam int unsigned CNT_W = (RAMP_CYCLES > 1) ? $clog2(RAMP_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RAMP_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // count ticks within a ramp, restart after the peak or on clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign peak = (cnt_q == LAST);
endmodule

// File: rtl/rail_seq_fsm.sv
// Sequence and fault controller: advances the ramp number at each timer peak,
// applies the boost and rail checks at their sample points and holds a fault
// latch that only a low on run_ok (enable and supply-ok) releases.
// Assumes the timer peaks once per ramp and is cleared whenever timer_clr is high.
module rail_seq_fsm
    import rail_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_ok,
    input  logic             peak,
    input  logic             therm_trip,
    input  logic             boost_good,
    input  logic             neg_good,
    input  logic             pos_good,
    output logic [IDX_W-1:0] idx,
    output logic             fault,
    output logic             timer_clr
);
    logic [IDX_W-1:0] idx_q;
    logic             fault_q;
    logic             boost_chk;
    logic             rail_chk;
    logic             fault_now;

    // decide in which cycles each good flag is enforced, and the fault term
    always_comb begin
        boost_chk = ((idx_q == STG_BOOST_CHK) && peak) || (idx_q > STG_BOOST_CHK);
        rail_chk  = ((idx_q == STG_RAIL_CHK) && peak) || (idx_q == IDX_DONE);
        fault_now = therm_trip
                  || (boost_chk && !boost_good)
                  || (rail_chk && !(neg_good && pos_good));
    end

    // ramp number and fault latch
    always_ff @(posedge clk) begin
        if (!rst_n || !run_ok) begin
            idx_q   <= IDX_IDLE;
            fault_q <= 1'b0;
        end else if (fault_q) begin
            idx_q   <= IDX_IDLE;
            fault_q <= 1'b1;
        end else if (fault_now) begin
            idx_q   <= IDX_IDLE;
            fault_q <= 1'b1;
        end else if (idx_q == IDX_IDLE) begin
            idx_q   <= 3'd1;
        end else if ((idx_q != IDX_DONE) && peak) begin
            idx_q   <= idx_q + 3'd1;
        end
    end

    assign timer_clr = !run_ok || fault_q || fault_now
                     || (idx_q == IDX_IDLE) || (idx_q == IDX_DONE);
    assign idx   = idx_q;
    assign fault = fault_q;

    // R1: a low on enable or supply-ok returns to idle with the latch clear
    a_r1_release: assert property (@(posedge clk) disable iff (!rst_n)
        !run_ok |=> (idx_q == IDX_IDLE) && !fault_q);

    // R10: the latch holds while the supply stays enabled
    a_r10_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        run_ok && fault_q |=> fault_q && (idx_q == IDX_IDLE));

    // R9: thermal trip always faults
    a_r9_thermal: assert property (@(posedge clk) disable iff (!rst_n)
        run_ok && therm_trip |=> fault_q);

    // R8: a boost drop after its check faults
    a_r8_boost_drop: assert property (@(posedge clk) disable iff (!rst_n)
        run_ok && !fault_q && (idx_q > STG_BOOST_CHK) && !boost_good |=> fault_q);

    // R8: a rail drop after completion faults
    a_r8_rail_drop: assert property (@(posedge clk) disable iff (!rst_n)
        run_ok && !fault_q && (idx_q == IDX_DONE) && !(neg_good && pos_good) |=> fault_q);

    // R2: the ramp number moves by at most one step, or drops to idle on fault
    a_r2_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
        run_ok && !fault_q && (idx_q != IDX_IDLE) && (idx_q != IDX_DONE)
        |=> (idx_q == $past(idx_q)) || (idx_q == $past(idx_q) + 3'd1) || fault_q);
endmodule

// File: rtl/rail_seq_switch.sv
// Output switch select: one-hot ground/lower/upper path, held on ground until
// the sequence is done, then following the control pin. Every change of path
// passes through one cycle with all paths open (break before make).
// Assumes done and ctl are synchronous to clk.
module rail_seq_switch
    import rail_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       done,
    input  logic       ctl,
    output logic [2:0] sel
);
    path_t tgt;
    path_t sel_q;

    // requested path
    always_comb begin
        if (!done) begin
            tgt = PATH_GND;
        end else if (ctl) begin
            tgt = PATH_HIGH;
        end else begin
            tgt = PATH_LOW;
        end
    end

    // move toward the requested path via the all-open state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= PATH_GND;
        end else if (sel_q == tgt) begin
            sel_q <= sel_q;
        end else if (sel_q != PATH_OFF) begin
            sel_q <= PATH_OFF;
        end else begin
            sel_q <= tgt;
        end
    end

    assign sel = sel_q;

    // R12: never two paths at once
    a_r12_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // R12: a closed path never changes straight into another closed path
    a_r12_break_first: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != 3'b000) && ($past(sel) != 3'b000) |-> sel == $past(sel));

    // R11: rail paths only around completion
    a_r11_rails_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (sel[1] || sel[2]) |-> (done || $past(done)));
endmodule

// File: rtl/rail_seq_ctrl.sv
// Top of the display supply power-up sequencer. Ties the ramp timer, the
// sequence/fault controller and the switch select together and decodes the
// rail enables from the ramp number.
// Assumes synchronous inputs and RAMP_CYCLES >= 2.
module rail_seq_ctrl
    import rail_seq_pkg::*;
#(
    parameter int unsigned RAMP_CYCLES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 vin_ok,
    input  logic                 therm_trip,
    input  logic                 boost_good,
    input  logic                 neg_good,
    input  logic                 pos_good,
    input  logic                 ctl,
    output logic [NUM_RAILS-1:0] rail_en,
    output logic                 sw_gnd,
    output logic                 sw_low,
    output logic                 sw_high,
    output logic [IDX_W-1:0]     ramp_idx,
    output logic                 seq_done,
    output logic                 fault_latched
);
    logic             run_ok;
    logic             peak;
    logic             timer_clr;
    logic [IDX_W-1:0] idx;
    logic             fault;
    logic [2:0]       sel;

    assign run_ok = en && vin_ok;

    rail_seq_timer #(.RAMP_CYCLES(RAMP_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (timer_clr),
        .peak  (peak)
    );

    rail_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_ok     (run_ok),
        .peak       (peak),
        .therm_trip (therm_trip),
        .boost_good (boost_good),
        .neg_good   (neg_good),
        .pos_good   (pos_good),
        .idx        (idx),
        .fault      (fault),
        .timer_clr  (timer_clr)
    );

    assign seq_done = (idx == IDX_DONE);

    rail_seq_switch u_switch (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (seq_done),
        .ctl   (ctl),
        .sel   (sel)
    );

    // each rail enable is high from its own ramp number onward
    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail_en
        assign rail_en[g] = (idx >= rail_on_stage(g));
    end

    assign sw_gnd        = sel[0];
    assign sw_low        = sel[1];
    assign sw_high       = sel[2];
    assign ramp_idx      = idx;
    assign fault_latched = fault;

    // R10: in a latched fault the ramp restarts only after a release
    a_r10_restart_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
        fault_latched && run_ok |=> !rail_en[0]);
endmodule

// File: tb/rail_seq_ctrl_tb.sv
module rail_seq_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RAMP       = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0, en = 1'b0, vin_ok = 1'b0, therm_trip = 1'b0;
    logic boost_good = 1'b0, neg_good = 1'b0, pos_good = 1'b0, ctl = 1'b0;
    logic [3:0] rail_en;
    logic sw_gnd, sw_low, sw_high, seq_done, fault_latched;
    logic [2:0] ramp_idx;

    always #(CLK_PERIOD/2) clk = ~clk;

    rail_seq_ctrl #(.RAMP_CYCLES(RAMP)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .vin_ok(vin_ok), .therm_trip(therm_trip),
        .boost_good(boost_good), .neg_good(neg_good), .pos_good(pos_good), .ctl(ctl),
        .rail_en(rail_en), .sw_gnd(sw_gnd), .sw_low(sw_low), .sw_high(sw_high),
        .ramp_idx(ramp_idx), .seq_done(seq_done), .fault_latched(fault_latched)
    );

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference: ramp number, tick within ramp, fault, switch path
    int m_ramp = 0;
    int m_tick = 0;
    bit m_fault = 1'b0;
    int m_sw = 1;   // 0 open, 1 ground, 2 lower, 4 upper

    always @(posedge clk) begin
        int tgt;
        bit run;
        bit bad;
        tgt = (m_ramp == 7) ? (ctl ? 4 : 2) : 1;
        if (!rst_n)           m_sw = 1;
        else if (m_sw == tgt) m_sw = m_sw;
        else if (m_sw != 0)   m_sw = 0;
        else                  m_sw = tgt;
        run = en && vin_ok;
        bad = therm_trip
            || (m_ramp == 3 && m_tick == RAMP-1 && !boost_good)
            || (m_ramp >= 4 && !boost_good)
            || (m_ramp == 6 && m_tick == RAMP-1 && !(neg_good && pos_good))
            || (m_ramp == 7 && !(neg_good && pos_good));
        if (!rst_n || !run) begin
            m_ramp = 0; m_tick = 0; m_fault = 1'b0;
        end else if (m_fault) begin
            m_ramp = 0;
        end else if (bad) begin
            m_fault = 1'b1; m_ramp = 0; m_tick = 0;
        end else if (m_ramp == 0) begin
            m_ramp = 1; m_tick = 0;
        end else if (m_ramp < 7) begin
            if (m_tick == RAMP-1) begin m_ramp++; m_tick = 0; end
            else m_tick++;
        end
    end

    // compare every output with the model on every cycle
    always @(negedge clk) begin
        if (!finished) begin
            chk("R2 ramp_idx", int'(ramp_idx), m_ramp);
            chk("R7 seq_done", int'(seq_done), int'(m_ramp == 7));
            chk("R3 ref enable", int'(rail_en[0]), int'(m_ramp >= 2));
            chk("R4 boost enable", int'(rail_en[1]), int'(m_ramp >= 3));
            chk("R6 negative enable", int'(rail_en[2]), int'(m_ramp >= 5));
            chk("R6 positive enable", int'(rail_en[3]), int'(m_ramp >= 6));
            chk("R10 fault latch", int'(fault_latched), int'(m_fault));
            chk("R12 switch select", int'({sw_high, sw_low, sw_gnd}), m_sw);
        end
    end

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        edges(3);
        chk("R1 reset ramp_idx", int'(ramp_idx), 0);
        chk("R1 reset enables", int'(rail_en), 0);
        chk("R1 reset ground path", int'(sw_gnd), 1);
        chk("R1 reset fault", int'(fault_latched), 0);
        rst_n = 1'b1;
        boost_good = 1'b1; neg_good = 1'b1; pos_good = 1'b1;
        en = 1'b1; vin_ok = 1'b1;

        // full sequence
        edges(1);
        chk("R2 first ramp", int'(ramp_idx), 1);
        edges(RAMP-1);
        chk("R3 ref off before first peak", int'(rail_en[0]), 0);
        edges(1);
        chk("R3 ref on after first peak", int'(rail_en[0]), 1);
        chk("R2 second ramp", int'(ramp_idx), 2);
        edges(RAMP);
        chk("R4 boost on at ramp 3", int'(rail_en[1]), 1);
        edges(2*RAMP);
        chk("R6 negative on at fourth peak", int'(rail_en[2]), 1);
        chk("R6 positive still off", int'(rail_en[3]), 0);
        edges(RAMP);
        chk("R6 positive on at ramp 6", int'(rail_en[3]), 1);
        edges(RAMP);
        chk("R7 done after ramp 6", int'(seq_done), 1);
        chk("R11 still ground at done", int'(sw_gnd), 1);
        edges(1);
        chk("R12 open gap", int'({sw_high, sw_low, sw_gnd}), 0);
        edges(1);
        chk("R11 lower path with ctl low", int'(sw_low), 1);
        ctl = 1'b1;
        edges(1);
        chk("R12 open gap on ctl change", int'({sw_high, sw_low, sw_gnd}), 0);
        edges(1);
        chk("R11 upper path with ctl high", int'(sw_high), 1);

        // rail drop after completion
        neg_good = 1'b0;
        edges(1);
        chk("R8 negative drop faults", int'(fault_latched), 1);
        chk("R10 enables off", int'(rail_en), 0);
        edges(1);
        chk("R12 open gap on fault", int'({sw_high, sw_low, sw_gnd}), 0);
        edges(1);
        chk("R10 back to ground", int'(sw_gnd), 1);
        neg_good = 1'b1;
        edges(5);
        chk("R10 latch holds", int'(fault_latched), 1);
        en = 1'b0;
        edges(1);
        chk("R10 enable low clears", int'(fault_latched), 0);
        en = 1'b1;
        edges(1);
        chk("R10 restart", int'(ramp_idx), 1);

        // boost check fails at end of ramp 3
        boost_good = 1'b0;
        edges(3*RAMP-1);
        chk("R5 no fault before sample", int'(fault_latched), 0);
        chk("R5 boost enabled", int'(rail_en[1]), 1);
        edges(1);
        chk("R5 boost check fault", int'(fault_latched), 1);
        vin_ok = 1'b0;
        edges(1);
        chk("R10 supply drop clears", int'(fault_latched), 0);
        vin_ok = 1'b1; boost_good = 1'b1;
        edges(1);
        chk("R10 restart after supply", int'(ramp_idx), 1);

        // boost drop after its check passed
        edges(4*RAMP);
        chk("R6 ramp 5 reached", int'(ramp_idx), 5);
        boost_good = 1'b0;
        edges(1);
        chk("R8 boost drop faults", int'(fault_latched), 1);
        boost_good = 1'b1; en = 1'b0;
        edges(1);
        en = 1'b1;
        edges(1);

        // positive rail fails final check
        pos_good = 1'b0;
        edges(6*RAMP-1);
        chk("R7 no fault before final sample", int'(fault_latched), 0);
        chk("R7 in ramp 6", int'(ramp_idx), 6);
        edges(1);
        chk("R7 final check fault", int'(fault_latched), 1);
        chk("R7 not done", int'(seq_done), 0);
        pos_good = 1'b1; en = 1'b0;
        edges(1);
        en = 1'b1;
        edges(1);

        // thermal trip in ramp 1
        edges(2);
        therm_trip = 1'b1;
        edges(1);
        chk("R9 thermal fault in ramp 1", int'(fault_latched), 1);
        therm_trip = 1'b0;
        edges(3);
        chk("R10 thermal latch holds", int'(fault_latched), 1);
        vin_ok = 1'b0;
        edges(1);
        chk("R1 supply low idle", int'(ramp_idx), 0);
        vin_ok = 1'b1;
        edges(1);
        chk("R2 restart after thermal", int'(ramp_idx), 1);
        edges(2);
        summary();
    end
endmodule